// File: doc/BRIEF.md
# Cylinder Seek and Reload Controller

This block carries out a head-positioning command for a disk-drive emulator entirely in hardware. The emulator keeps one whole cylinder in an on-chip track buffer so that switching heads is only a change of buffer address. When a new cylinder is requested, the controller first copies every track that was modified since the last load back to the external image store. It then streams the requested cylinder from the store into the buffer, one 32-bit word per transfer, and reports completion.

The image store is reached through a simple word port. The block raises a request and holds it, together with the address, direction and write data, until the store returns a one-cycle acknowledge. The track buffer is a synchronous RAM with one cycle of read latency. The read/write path of the emulator tells the controller which heads it has modified by pulsing a mark input. A target outside the configured cylinder count is rejected with an error pulse. A target equal to the loaded cylinder completes at once without any transfer.

The geometry (heads per cylinder, 32-bit words per track) is set by parameters. The image base address and the cylinder count are configuration inputs. After reset the buffer is taken to hold cylinder 0 with every track clean.

Top module: `seek_reload_ctrl`

## Requirements
- R1: After reset `busy`, `seek_done`, `seek_err` and `mem_req` are low, the loaded cylinder is 0 and no track is marked modified.
- R2: A command to an in-range cylinder that differs from the loaded one makes `busy` high from the cycle after `cmd_valid`. `busy` stays high until the operation ends, and it falls in the same cycle that `seek_done` pulses high for exactly one cycle.
- R3: A `cmd_valid` that arrives while `busy` is high is ignored: it does not change the target and produces no extra completion.
- R4: Before any fill read, every modified track of the loaded cylinder is written to the store (`mem_we`=1) in ascending head order, words 0 to WPT-1 in ascending order, with the data held at buffer address head*WPT+word. Clean tracks are not written.
- R5: Every store transfer uses address `cfg_base` + (cylinder*HEADS + head)*WPT + word. Write-back uses the loaded cylinder and the fill uses the target cylinder.
- R6: The fill performs HEADS*WPT reads (`mem_we`=0) in head-major, ascending-word order. Each acknowledged word is written to buffer address head*WPT+word in the acknowledge cycle.
- R7: A command whose cylinder equals the loaded one pulses `seek_done` in the next cycle without raising `busy` or `mem_req`.
- R8: A command with `cmd_cyl` >= `cfg_cyls` pulses `seek_err` in the next cycle without raising `busy`, `mem_req` or `seek_done`. The buffer, the loaded cylinder and the modified-track set stay unchanged.
- R9: A `mark_valid` pulse while idle records head `mark_head` as modified. Marks while busy are ignored. After a completed reload no track is modified.
- R10: Once raised, `mem_req` stays high with a stable `mem_addr` and `mem_we` until `mem_ack` is seen.
- R11: With `cfg_cyls` = 65536, cylinder 65535 is accepted and addressed through a 16-bit target field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Word address of cylinder 0, head 0, word 0 in the store |
| cfg_cyls | input | CW+1 | Number of cylinders in the image |
| cmd_valid | input | 1 | One-cycle seek command strobe |
| cmd_cyl | input | CW | Target cylinder |
| mark_valid | input | 1 | Track-modified strobe from the read/write path |
| mark_head | input | HW | Head whose track was modified |
| busy | output | 1 | Reload in progress |
| seek_done | output | 1 | One-cycle completion pulse |
| seek_err | output | 1 | One-cycle out-of-range pulse |
| mem_req | output | 1 | Store transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = write to store, 0 = read from store |
| mem_addr | output | AW | Store word address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| buf_addr | output | BAW | Track buffer word address |
| buf_we | output | 1 | Track buffer write enable |
| buf_wdata | output | 32 | Track buffer write data |
| buf_rdata | input | 32 | Track buffer read data, one cycle after `buf_addr` |

## Verification
The assertions check the handshake rules on every cycle. A pending request keeps its address and direction, the idle controller never requests and never writes the buffer, a buffer write only happens on an acknowledged read, the fall of busy coincides with the done pulse, and an error pulse never appears beside busy or done. Only the bench scenarios can show the transfer sequence itself: which tracks are written back and in what order, the computed addresses, the final buffer contents, and that ignored commands and marks leave the later behaviour unchanged. The bench observes these through the store log and the follow-up seeks.

// File: rtl/seek_pkg.sv
package seek_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FL_RD = 2'd1,
        ST_FL_WR = 2'd2,
        ST_FILL  = 2'd3
    } seek_state_e;
endpackage

// File: rtl/seek_track_pick.sv
module seek_track_pick #(
    parameter int HEADS = 4,
    localparam int HW = $clog2(HEADS)
) (
    input  logic [HEADS-1:0] pend,
    output logic             found,
    output logic [HW-1:0]    idx
);
    // Lowest pending head wins: each bit sees whether any lower bit is set.
    logic [HEADS:0] lower_any;
    logic [HEADS-1:0] win;

    assign lower_any[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < HEADS; g++) begin : g_chain
            assign win[g]         = pend[g] & ~lower_any[g];
            assign lower_any[g+1] = lower_any[g] | pend[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < HEADS; i++) begin
            if (win[i]) idx = HW'(i);
        end
    end

    assign found = lower_any[HEADS];
endmodule

// File: rtl/seek_addr_gen.sv
module seek_addr_gen #(
    parameter int HEADS = 4,
    parameter int WPT   = 8,
    parameter int AW    = 32,
    parameter int CW    = 16,
    localparam int HW   = $clog2(HEADS),
    localparam int WW   = $clog2(WPT),
    localparam int BAW  = $clog2(HEADS * WPT)
) (
    input  logic [AW-1:0]  base,
    input  logic [CW-1:0]  cyl,
    input  logic [HW-1:0]  head,
    input  logic [WW-1:0]  word,
    output logic [AW-1:0]  mem_addr,
    output logic [BAW-1:0] buf_addr
);
    logic [AW-1:0] trk_idx;

    always_comb begin
        trk_idx  = AW'(cyl) * AW'(HEADS) + AW'(head);
        mem_addr = base + trk_idx * AW'(WPT) + AW'(word);
        buf_addr = BAW'(head) * BAW'(WPT) + BAW'(word);
    end
endmodule

// File: rtl/seek_reload_ctrl.sv
module seek_reload_ctrl #(
    parameter int HEADS = 4,
    parameter int WPT   = 8,
    parameter int AW    = 32,
    parameter int CW    = 16,
    localparam int HW   = $clog2(HEADS),
    localparam int WW   = $clog2(WPT),
    localparam int BAW  = $clog2(HEADS * WPT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cfg_base,
    input  logic [CW:0]    cfg_cyls,
    input  logic           cmd_valid,
    input  logic [CW-1:0]  cmd_cyl,
    input  logic           mark_valid,
    input  logic [HW-1:0]  mark_head,
    output logic           busy,
    output logic           seek_done,
    output logic           seek_err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ack,
    input  logic [31:0]    mem_rdata,
    output logic [BAW-1:0] buf_addr,
    output logic           buf_we,
    output logic [31:0]    buf_wdata,
    input  logic [31:0]    buf_rdata
);
    import seek_pkg::*;

    typedef struct packed {
        seek_state_e      st;
        logic [CW-1:0]    cur;
        logic [CW-1:0]    tgt;
        logic [HW-1:0]    head;
        logic [WW-1:0]    word;
        logic [HEADS-1:0] dirty;
        logic             done;
        logic             err;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic [HEADS-1:0] head_oh, mark_oh, pick_in;
    logic             pick_found;
    logic [HW-1:0]    pick_idx;
    logic             last_word, last_head;
    logic [CW-1:0]    cyl_sel;

    assign head_oh   = HEADS'(1) << r_q.head;
    assign mark_oh   = mark_valid ? (HEADS'(1) << mark_head) : '0;
    assign pick_in   = (r_q.st == ST_IDLE) ? (r_q.dirty | mark_oh)
                                           : (r_q.dirty & ~head_oh);
    assign last_word = (r_q.word == WW'(WPT - 1));
    assign last_head = (r_q.head == HW'(HEADS - 1));
    assign cyl_sel   = (r_q.st == ST_FILL) ? r_q.tgt : r_q.cur;

    seek_track_pick #(.HEADS(HEADS)) pick_i (
        .pend  (pick_in),
        .found (pick_found),
        .idx   (pick_idx)
    );

    seek_addr_gen #(.HEADS(HEADS), .WPT(WPT), .AW(AW), .CW(CW)) agen_i (
        .base     (cfg_base),
        .cyl      (cyl_sel),
        .head     (r_q.head),
        .word     (r_q.word),
        .mem_addr (mem_addr),
        .buf_addr (buf_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.dirty = r_q.dirty | mark_oh;
                if (cmd_valid) begin
                    if ({1'b0, cmd_cyl} >= cfg_cyls) begin
                        r_d.err = 1'b1;
                    end else if (cmd_cyl == r_q.cur) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.tgt  = cmd_cyl;
                        r_d.word = '0;
                        if (pick_found) begin
                            r_d.head = pick_idx;
                            r_d.st   = ST_FL_RD;
                        end else begin
                            r_d.head = '0;
                            r_d.st   = ST_FILL;
                        end
                    end
                end
            end
            ST_FL_RD: begin
                r_d.st = ST_FL_WR;
            end
            ST_FL_WR: begin
                if (mem_ack) begin
                    if (last_word) begin
                        r_d.dirty = r_q.dirty & ~head_oh;
                        r_d.word  = '0;
                        if (pick_found) begin
                            r_d.head = pick_idx;
                            r_d.st   = ST_FL_RD;
                        end else begin
                            r_d.head = '0;
                            r_d.st   = ST_FILL;
                        end
                    end else begin
                        r_d.word = r_q.word + 1'b1;
                        r_d.st   = ST_FL_RD;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    if (last_word) begin
                        r_d.word = '0;
                        if (last_head) begin
                            r_d.head  = '0;
                            r_d.st    = ST_IDLE;
                            r_d.cur   = r_q.tgt;
                            r_d.dirty = '0;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.head = r_q.head + 1'b1;
                        end
                    end else begin
                        r_d.word = r_q.word + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cur: '0, tgt: '0, head: '0, word: '0,
                     dirty: '0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign seek_done = r_q.done;
    assign seek_err  = r_q.err;
    assign mem_req   = (r_q.st == ST_FL_WR) || (r_q.st == ST_FILL);
    assign mem_we    = (r_q.st == ST_FL_WR);
    assign mem_wdata = buf_rdata;
    assign buf_we    = (r_q.st == ST_FILL) && mem_ack;
    assign buf_wdata = mem_rdata;
endmodule

// File: rtl/seek_reload_ctrl_chk.sv
module seek_reload_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          seek_done,
    input logic          seek_err,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          buf_we
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !buf_we));

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> seek_done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seek_done |-> !busy);

    assert_err_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seek_err |-> (!busy && !seek_done));

    assert_buf_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (mem_req && mem_ack && !mem_we));
endmodule

bind seek_reload_ctrl seek_reload_ctrl_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .seek_done (seek_done),
    .seek_err  (seek_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .buf_we    (buf_we)
);

// File: tb/seek_reload_ctrl_tb_top.sv
module seek_reload_ctrl_tb_top;
    localparam int HEADS = 4;
    localparam int WPT   = 8;
    localparam int AW    = 32;
    localparam int CW    = 16;
    localparam int HW    = $clog2(HEADS);
    localparam int BAW   = $clog2(HEADS * WPT);
    localparam int NBUF  = HEADS * WPT;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] cfg_base = BASE;
    logic [CW:0]   cfg_cyls = 17'd1000;
    logic cmd_valid = 1'b0;
    logic [CW-1:0] cmd_cyl = '0;
    logic mark_valid = 1'b0;
    logic [HW-1:0] mark_head = '0;
    logic busy, seek_done, seek_err, mem_req, mem_we, buf_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, buf_wdata;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [BAW-1:0] buf_addr;
    logic [31:0] buf_rdata = '0;

    always #2 clk = ~clk;

    seek_reload_ctrl #(.HEADS(HEADS), .WPT(WPT), .AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_cyls(cfg_cyls),
        .cmd_valid(cmd_valid), .cmd_cyl(cmd_cyl),
        .mark_valid(mark_valid), .mark_head(mark_head),
        .busy(busy), .seek_done(seek_done), .seek_err(seek_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    function automatic logic [31:0] img(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] eaddr(input int c, input int h, input int w);
        return BASE + 32'((c * HEADS + h) * WPT + w);
    endfunction

    // Track buffer model: registered read, writes from the DUT or from the bench.
    logic [31:0] bmem [NBUF];
    logic tb_wr = 1'b0;
    logic [BAW-1:0] tb_waddr = '0;
    logic [31:0] tb_wdata = '0;
    always @(posedge clk) begin
        if (tb_wr) bmem[tb_waddr] <= tb_wdata;
        else if (buf_we) bmem[buf_addr] <= buf_wdata;
        buf_rdata <= bmem[buf_addr];
    end

    // Image store responder and transfer log.
    int lat = 0;
    int cnt = 0;
    logic log_clr = 1'b0;
    int n_log = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    logic [31:0] log_addr [128];
    logic        log_we   [128];
    logic [31:0] log_dat  [128];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= img(mem_addr);
                cnt <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
        if (log_clr) begin
            n_log <= 0; done_cnt <= 0; err_cnt <= 0;
        end else begin
            if (mem_req && mem_ack && n_log < 128) begin
                log_addr[n_log] <= mem_addr;
                log_we[n_log]   <= mem_we;
                log_dat[n_log]  <= mem_wdata;
                n_log <= n_log + 1;
            end
            if (seek_done) done_cnt <= done_cnt + 1;
            if (seek_err)  err_cnt  <= err_cnt + 1;
        end
    end

    int tests = 0;
    int fails = 0;
    int model_cur = 0;
    logic [HEADS-1:0] model_dirty = '0;
    logic [31:0] exp_buf [NBUF];
    int seq = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mark_tracks(input logic [HEADS-1:0] mask);
        for (int h = 0; h < HEADS; h++) begin
            if (mask[h]) begin
                seq++;
                for (int w = 0; w < WPT; w++) begin
                    tb_wr = 1'b1;
                    tb_waddr = BAW'(h * WPT + w);
                    tb_wdata = {8'hC0, 8'(seq), 8'(h), 8'(w)};
                    exp_buf[h * WPT + w] = tb_wdata;
                    @(negedge clk);
                end
                tb_wr = 1'b0;
                mark_valid = 1'b1;
                mark_head = HW'(h);
                @(negedge clk);
                mark_valid = 1'b0;
                model_dirty[h] = 1'b1;
            end
        end
    endtask

    task automatic clear_log();
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            if (done_cnt + err_cnt > 0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // Issue one seek and check everything the requirements predict for it.
    task automatic do_seek(input logic [HEADS-1:0] mask, input int tgt);
        int e_n;
        logic [31:0] e_addr [128];
        logic        e_we   [128];
        logic [31:0] e_dat  [128];
        bit seq_ok;
        bit buf_ok;
        int bad;
        mark_tracks(mask);
        clear_log();
        cmd_valid = 1'b1;
        cmd_cyl = CW'(tgt);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (tgt >= int'(cfg_cyls)) begin
            check(!busy && seek_err, "R8", "error pulse without busy",
                  {30'd0, busy, seek_err}, 32'd1);
            wait_end();
            check(err_cnt == 1 && done_cnt == 0 && n_log == 0, "R8",
                  "no transfer or completion on error", 32'(n_log), 32'd0);
            buf_ok = 1'b1;
            for (int i = 0; i < NBUF; i++) if (bmem[i] !== exp_buf[i]) buf_ok = 1'b0;
            check(buf_ok, "R8", "buffer unchanged after error", 32'(buf_ok), 32'd1);
        end else if (tgt == model_cur) begin
            check(!busy && seek_done, "R7", "immediate completion",
                  {30'd0, busy, seek_done}, 32'd1);
            wait_end();
            check(done_cnt == 1 && n_log == 0, "R7", "no transfers for same cylinder",
                  32'(n_log), 32'd0);
        end else begin
            check(busy, "R2", "busy after accept", 32'(busy), 32'd1);
            e_n = 0;
            for (int h = 0; h < HEADS; h++) begin
                if (model_dirty[h]) begin
                    for (int w = 0; w < WPT; w++) begin
                        e_addr[e_n] = eaddr(model_cur, h, w);
                        e_we[e_n] = 1'b1;
                        e_dat[e_n] = exp_buf[h * WPT + w];
                        e_n++;
                    end
                end
            end
            for (int h = 0; h < HEADS; h++) begin
                for (int w = 0; w < WPT; w++) begin
                    e_addr[e_n] = eaddr(tgt, h, w);
                    e_we[e_n] = 1'b0;
                    e_dat[e_n] = 32'd0;
                    exp_buf[h * WPT + w] = img(eaddr(tgt, h, w));
                    e_n++;
                end
            end
            wait_end();
            check(done_cnt == 1 && !busy, "R2", "single completion pulse, busy low",
                  32'(done_cnt), 32'd1);
            check(n_log == e_n, "R4", "transfer count (write-back + fill)",
                  32'(n_log), 32'(e_n));
            seq_ok = 1'b1;
            bad = 0;
            for (int i = 0; i < e_n && i < n_log; i++) begin
                if (log_addr[i] !== e_addr[i] || log_we[i] !== e_we[i] ||
                    (e_we[i] && log_dat[i] !== e_dat[i])) begin
                    if (seq_ok) bad = i;
                    seq_ok = 1'b0;
                end
            end
            check(seq_ok, "R5", "transfer address/direction/data sequence",
                  log_addr[bad], e_addr[bad]);
            buf_ok = 1'b1;
            bad = 0;
            for (int i = 0; i < NBUF; i++) begin
                if (bmem[i] !== exp_buf[i]) begin
                    if (buf_ok) bad = i;
                    buf_ok = 1'b0;
                end
            end
            check(buf_ok, "R6", "buffer filled from target cylinder", bmem[bad], exp_buf[bad]);
            model_cur = tgt;
            model_dirty = '0;
        end
    endtask

    // {modified-track mask, target cylinder}
    localparam logic [19:0] VEC [7] = '{
        {4'b0000, 16'd5},
        {4'b0101, 16'd6},
        {4'b1111, 16'd999},
        {4'b0000, 16'd999},
        {4'b1000, 16'd1000},
        {4'b0000, 16'd3},
        {4'b0010, 16'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBUF; i++) exp_buf[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !seek_done && !seek_err && !mem_req, "R1", "idle after reset",
              {28'd0, busy, seek_done, seek_err, mem_req}, 32'd0);

        // R1 R4 R5 R6 R7 R8 R9 via the vector table. Vector 5 marks head 3,
        // is rejected, and vector 6 must still write head 3 back (R8, R9).
        for (int v = 0; v < 7; v++) begin
            lat = v % 4;
            do_seek(VEC[v][19:16], int'(VEC[v][15:0]));
        end

        // R3 and R9: command and mark during a busy reload are ignored.
        lat = 3;
        clear_log();
        cmd_valid = 1'b1; cmd_cyl = 16'd10;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        cmd_valid = 1'b1; cmd_cyl = 16'd20;
        mark_valid = 1'b1; mark_head = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0; mark_valid = 1'b0;
        wait_end();
        check(done_cnt == 1, "R3", "one completion despite second command",
              32'(done_cnt), 32'd1);
        for (int h = 0; h < HEADS; h++)
            for (int w = 0; w < WPT; w++)
                exp_buf[h * WPT + w] = img(eaddr(10, h, w));
        model_cur = 10;
        model_dirty = '0;
        do_seek(4'b0000, 10);   // R3: still cylinder 10
        do_seek(4'b0000, 12);   // R9: busy-time mark gave no write-back

        // R9: a mark in the same idle cycle as another mark path, then clean after reload
        do_seek(4'b1001, 13);
        do_seek(4'b0000, 14);

        // R11: full 16-bit cylinder range
        cfg_cyls = 17'd65536;
        lat = 1;
        do_seek(4'b0001, 65535);
        do_seek(4'b0100, 0);
        do_seek(4'b0000, 65536 - 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule